// File: doc/BRIEF.md
# E1 Periodic Event Status Register

This block raises and holds the periodic timing flags of one E1 line at 2.048 Mb/s. Two free-running bit counters, one on the receive clock and one on the transmit clock, divide the line down to frames of 256 bits. They mark align-frame boundaries every two frames and multiframe boundaries every sixteen frames. The receive side also runs a timer of 8000 frames (one second), or 500 frames (62.5 ms) when a control input selects the fast rate. It also marks CRC-4 multiframe starts. When CRC-4 is enabled these come from the frame aligner. When CRC-4 is off, the free-running multiframe boundary is used instead. A detect pulse from an external pseudorandom pattern checker is passed through while the checker is enabled.

A watchdog in the host clock domain samples the transmit clock and reports once when that clock has been still for a programmable number of host cycles (about 3.9 ms by default). Every event crosses into the host clock domain and sets one sticky bit of an 8-bit status register. The host reads the register at address 0x0B and clears bits by writing ones to them.

Top module: `e1evt_status_reg`

## Requirements
- R1: While `rst_n` is low the status register is cleared to 0x00, and after reset it reads 0x00 until an event occurs.
- R2: Bit 6 is set once every 2 x BITS_PER_FRAME receive clocks after receive reset (receive align frame), and each boundary sets it exactly once.
- R3: Bit 3 is set once every 2 x BITS_PER_FRAME transmit clocks after transmit reset (transmit align frame).
- R4: Bit 7 is set once every 16 frames of receive clocks and bit 5 once every 16 frames of transmit clocks (multiframe boundaries).
- R5: Bit 4 is set once every FRAMES_PER_SEC receive frames while `timer_fast` is 0, and once every FRAMES_FAST receive frames while it is 1.
- R6: With `rx_crc4_en` at 1, bit 1 is set once for each receive clock that samples `rx_crc_mark` high. With `rx_crc4_en` at 0, `rx_crc_mark` is ignored and bit 1 follows the 16-frame receive boundary.
- R7: Bit 0 is set when `rx_pat_hit` is sampled high while `rx_pat_en` is 1. A hit sampled while `rx_pat_en` is 0 leaves bit 0 clear.
- R8: Bit 2 is set once when `tx_clk` has shown no edge for LOSS_CYCLES host clocks. It is not set while `tx_clk` toggles, and it is not set again during the same outage.
- R9: A write to address STATUS_ADDR (default 0x0B) clears exactly the bits written as 1, and bits written as 0 are unchanged. A write to any other address changes nothing, and a read of any other address returns 0x00.
- R10: When an event and a clear of the same bit fall in the same host cycle, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock, also the free-running reference for the transmit clock watchdog |
| rst_n | input | 1 | Synchronous active-low reset of the host domain |
| host_addr | input | ADDR_W | Register address for reads and writes |
| host_wr | input | 1 | Write strobe, one host cycle per write |
| host_wdata | input | 8 | Write data, a 1 clears the matching status bit |
| host_rdata | output | 8 | Status register when `host_addr` is STATUS_ADDR, else 0 |
| timer_fast | input | 1 | Receive-domain level: 1 selects the short timer period |
| rx_clk | input | 1 | Receive bit clock |
| rx_rst_n | input | 1 | Synchronous active-low reset of the receive domain |
| rx_crc4_en | input | 1 | Receive-domain level: 1 takes CRC-4 multiframe marks from `rx_crc_mark` |
| rx_crc_mark | input | 1 | Receive-domain pulse at each CRC-4 multiframe start |
| rx_pat_en | input | 1 | Receive-domain level: pattern checker enabled |
| rx_pat_hit | input | 1 | Receive-domain pulse: pattern detected |
| tx_clk | input | 1 | Transmit bit clock, also watched for loss |
| tx_rst_n | input | 1 | Synchronous active-low reset of the transmit domain |

## Verification
The bench steps the line clocks one edge at a time and reads and clears the register after each edge. This counts every flag exactly, so a divider that is off by one, a crossing that drops or repeats a pulse, or a timer that ignores the rate select shows up as a wrong count. CRC-4 marks and pattern hits are applied with their enables both on and off. A design that lets a mark through with CRC-4 off, or lets a hit through with the checker disabled, gives an extra count. A design that forgets the free-running boundary gives a missing count. The transmit clock is stopped for longer than the watchdog window to see one, and only one, loss flag. While the loss fires, the bench writes clears every cycle; if clear took priority over set, the flag would never be seen. Writes to a neighbouring address and writes of zeros are checked to leave flags intact.

// File: rtl/e1evt_pkg.sv
// Package: bit positions and the status word type shared by the event
// status register, its checker and its bench.
package e1evt_pkg;

    localparam int ST_W = 8;

    // Status bit positions; host software decodes these positions.
    localparam int B_RX_CAS   = 7;
    localparam int B_RX_ALIGN = 6;
    localparam int B_TX_MF    = 5;
    localparam int B_TIMER    = 4;
    localparam int B_TX_ALIGN = 3;
    localparam int B_TX_LOST  = 2;
    localparam int B_RX_CRC   = 1;
    localparam int B_PATTERN  = 0;

    typedef logic [ST_W-1:0] status_t;

endpackage

// File: rtl/e1evt_divider.sv
// Module: e1evt_divider
// Counts input ticks and emits one tick on every (last+1)-th input tick.
// Assumes: `last` may change at run time; a count already past the new
// limit wraps on the next input tick instead of running away.
module e1evt_divider #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_in,
    input  logic [W-1:0] last,
    output logic         tick_out
);
    logic [W-1:0] cnt;
    logic         at_end;

    // Terminal detection, tolerant of a lowered limit.
    assign at_end   = (cnt >= last);
    assign tick_out = tick_in && at_end;

    // Advance or wrap the count on each input tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (tick_in) begin
            cnt <= at_end ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/e1evt_frame_timer.sv
// Module: e1evt_frame_timer
// Divides a line bit clock into frames and derives the align-frame,
// multiframe and (optionally) timer boundary ticks, each one clock wide.
// Assumes: counting starts at reset; the first frame after reset is not
// itself flagged. ticks[0]=align, ticks[1]=multiframe, ticks[2]=timer.
module e1evt_frame_timer #(
    parameter int BITS_PER_FRAME   = 256,
    parameter int FRAMES_PER_ALIGN = 2,
    parameter int FRAMES_PER_MF    = 16,
    parameter int FRAMES_PER_SEC   = 8000,
    parameter int FRAMES_FAST      = 500,
    parameter bit HAS_TIMER        = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fast,
    output logic [1+HAS_TIMER:0] ticks
);
    localparam int BW   = $clog2(BITS_PER_FRAME + 1);
    localparam int FMAX = (FRAMES_PER_SEC > FRAMES_PER_MF) ? FRAMES_PER_SEC : FRAMES_PER_MF;
    localparam int FW   = $clog2(FMAX + 1);
    localparam logic [BW-1:0] BIT_LAST   = BW'(BITS_PER_FRAME - 1);
    localparam logic [FW-1:0] ALIGN_LAST = FW'(FRAMES_PER_ALIGN - 1);
    localparam logic [FW-1:0] MF_LAST    = FW'(FRAMES_PER_MF - 1);
    localparam logic [FW-1:0] SEC_LAST   = FW'(FRAMES_PER_SEC - 1);
    localparam logic [FW-1:0] FAST_LAST  = FW'(FRAMES_FAST - 1);

    logic frame_tick;

    e1evt_divider #(.W(BW)) u_bits (
        .clk(clk), .rst_n(rst_n), .tick_in(1'b1), .last(BIT_LAST), .tick_out(frame_tick)
    );

    e1evt_divider #(.W(FW)) u_align (
        .clk(clk), .rst_n(rst_n), .tick_in(frame_tick), .last(ALIGN_LAST), .tick_out(ticks[0])
    );

    e1evt_divider #(.W(FW)) u_mf (
        .clk(clk), .rst_n(rst_n), .tick_in(frame_tick), .last(MF_LAST), .tick_out(ticks[1])
    );

    generate
        if (HAS_TIMER) begin : g_timer
            logic [FW-1:0] tmr_last;
            // Pick the timer period from the rate select.
            assign tmr_last = fast ? FAST_LAST : SEC_LAST;
            e1evt_divider #(.W(FW)) u_tmr (
                .clk(clk), .rst_n(rst_n), .tick_in(frame_tick), .last(tmr_last),
                .tick_out(ticks[1+HAS_TIMER])
            );
        end else begin : g_no_timer
            logic unused_fast;
            assign unused_fast = fast;
        end
    endgenerate
endmodule

// File: rtl/e1evt_evt_xfer.sv
// Module: e1evt_evt_xfer
// Moves N single-cycle event pulses from a source clock domain to a
// destination domain: each pulse flips a toggle, which is synchronized by
// two flops and edge-detected into one destination pulse.
// Assumes: events on one lane are spaced by at least three destination
// cycles; both domains are reset together.
module e1evt_evt_xfer #(
    parameter int N = 1
) (
    input  logic         src_clk,
    input  logic         src_rst_n,
    input  logic [N-1:0] src_evt,
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    output logic [N-1:0] dst_evt
);
    logic [N-1:0] tog;
    logic [N-1:0] s1, s2, s3;

    // Source side: one toggle per lane.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) tog <= '0;
        else            tog <= tog ^ src_evt;
    end

    // Destination side: synchronize and keep the last value for edge detection.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) begin
            s1 <= '0;
            s2 <= '0;
            s3 <= '0;
        end else begin
            s1 <= tog;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign dst_evt = s2 ^ s3;
endmodule

// File: rtl/e1evt_clk_watch.sv
// Module: e1evt_clk_watch
// Watches a monitored clock from a free-running reference clock. The
// monitored clock passes a two-flop synchronizer; every edge seen restarts a
// timeout count. One pulse is issued when the count reaches LIMIT.
// Assumes: the reference clock is over twice as fast as the monitored one.
module e1evt_clk_watch #(
    parameter int LIMIT = 195000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mon_clk,
    output logic lost
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CNT_TOP  = CW'(LIMIT);
    localparam logic [CW-1:0] CNT_FIRE = CW'(LIMIT - 1);

    logic m1, m2, m3;
    logic seen;
    logic [CW-1:0] idle;

    // Synchronize the monitored clock and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m1 <= 1'b0;
            m2 <= 1'b0;
            m3 <= 1'b0;
        end else begin
            m1 <= mon_clk;
            m2 <= m1;
            m3 <= m2;
        end
    end

    assign seen = m2 ^ m3;
    assign lost = !seen && (idle == CNT_FIRE);

    // Idle counter: restarts on an edge, saturates at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)              idle <= '0;
        else if (seen)           idle <= '0;
        else if (idle != CNT_TOP) idle <= idle + 1'b1;
    end
endmodule

// File: rtl/e1evt_status_reg.sv
// Module: e1evt_status_reg (top)
// Event status register of one E1 line. Receive and transmit frame timers
// produce boundary events, which cross to the host clock; a watchdog on the
// host clock checks the transmit clock. Each event sets a sticky bit, and the
// host clears bits by writing ones at STATUS_ADDR. A set and a clear in the
// same cycle leave the bit set.
// Assumes: clk is free-running; the three resets are asserted together
// while every clock runs a few cycles.
module e1evt_status_reg
    import e1evt_pkg::*;
#(
    parameter int              ADDR_W           = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR    = 8'h0B,
    parameter int              BITS_PER_FRAME   = 256,
    parameter int              FRAMES_PER_ALIGN = 2,
    parameter int              FRAMES_PER_MF    = 16,
    parameter int              FRAMES_PER_SEC   = 8000,
    parameter int              FRAMES_FAST      = 500,
    parameter int              LOSS_CYCLES      = 195000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [ST_W-1:0]   host_wdata,
    output logic [ST_W-1:0]   host_rdata,
    input  logic              timer_fast,
    input  logic              rx_clk,
    input  logic              rx_rst_n,
    input  logic              rx_crc4_en,
    input  logic              rx_crc_mark,
    input  logic              rx_pat_en,
    input  logic              rx_pat_hit,
    input  logic              tx_clk,
    input  logic              tx_rst_n
);
    localparam int RX_N = 5;
    localparam int TX_N = 2;

    logic [2:0]      rx_ticks;
    logic [1:0]      tx_ticks;
    logic [RX_N-1:0] rx_evt, rx_h;
    logic [TX_N-1:0] tx_evt, tx_h;
    logic            tx_lost;
    logic            sel;
    status_t         st, set_v, clr_v;

    e1evt_frame_timer #(
        .BITS_PER_FRAME(BITS_PER_FRAME), .FRAMES_PER_ALIGN(FRAMES_PER_ALIGN),
        .FRAMES_PER_MF(FRAMES_PER_MF), .FRAMES_PER_SEC(FRAMES_PER_SEC),
        .FRAMES_FAST(FRAMES_FAST), .HAS_TIMER(1'b1)
    ) u_rx_tmr (
        .clk(rx_clk), .rst_n(rx_rst_n), .fast(timer_fast), .ticks(rx_ticks)
    );

    e1evt_frame_timer #(
        .BITS_PER_FRAME(BITS_PER_FRAME), .FRAMES_PER_ALIGN(FRAMES_PER_ALIGN),
        .FRAMES_PER_MF(FRAMES_PER_MF), .FRAMES_PER_SEC(FRAMES_PER_SEC),
        .FRAMES_FAST(FRAMES_FAST), .HAS_TIMER(1'b0)
    ) u_tx_tmr (
        .clk(tx_clk), .rst_n(tx_rst_n), .fast(1'b0), .ticks(tx_ticks)
    );

    // Receive-domain events: multiframe, align, timer, CRC-4 mark, pattern.
    always_comb begin
        rx_evt[4] = rx_ticks[1];
        rx_evt[3] = rx_ticks[0];
        rx_evt[2] = rx_ticks[2];
        rx_evt[1] = rx_crc4_en ? rx_crc_mark : rx_ticks[1];
        rx_evt[0] = rx_pat_en && rx_pat_hit;
    end

    // Transmit-domain events: multiframe, align.
    assign tx_evt = {tx_ticks[1], tx_ticks[0]};

    e1evt_evt_xfer #(.N(RX_N)) u_rx_xfer (
        .src_clk(rx_clk), .src_rst_n(rx_rst_n), .src_evt(rx_evt),
        .dst_clk(clk), .dst_rst_n(rst_n), .dst_evt(rx_h)
    );

    e1evt_evt_xfer #(.N(TX_N)) u_tx_xfer (
        .src_clk(tx_clk), .src_rst_n(tx_rst_n), .src_evt(tx_evt),
        .dst_clk(clk), .dst_rst_n(rst_n), .dst_evt(tx_h)
    );

    e1evt_clk_watch #(.LIMIT(LOSS_CYCLES)) u_watch (
        .clk(clk), .rst_n(rst_n), .mon_clk(tx_clk), .lost(tx_lost)
    );

    // Map host-domain events onto their status bit positions.
    always_comb begin
        set_v             = '0;
        set_v[B_RX_CAS]   = rx_h[4];
        set_v[B_RX_ALIGN] = rx_h[3];
        set_v[B_TIMER]    = rx_h[2];
        set_v[B_RX_CRC]   = rx_h[1];
        set_v[B_PATTERN]  = rx_h[0];
        set_v[B_TX_MF]    = tx_h[1];
        set_v[B_TX_ALIGN] = tx_h[0];
        set_v[B_TX_LOST]  = tx_lost;
    end

    assign sel   = (host_addr == STATUS_ADDR);
    assign clr_v = (host_wr && sel) ? host_wdata : '0;

    // Sticky bits: write-one-to-clear, with a new event overriding the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= '0;
        else        st <= (st & ~clr_v) | set_v;
    end

    assign host_rdata = sel ? st : '0;
endmodule

// File: rtl/e1evt_status_chk.sv
// Module: e1evt_status_chk
// Checker for the host side of the status register, bound to the top.
module e1evt_status_chk
    import e1evt_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h0B
) (
    input logic              clk,
    input logic              rst_n,
    input status_t           status,
    input status_t           set_v,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic [ST_W-1:0]   host_wdata,
    input logic              lost
);
    logic live;

    // One cycle of history after reset before history-based checks run.
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (status == '0));

    // R9
    clear_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
        (|($past(status) & ~status)) |->
            ($past(host_wr && host_addr == STATUS_ADDR) &&
             (($past(status) & ~status & ~$past(host_wdata)) == '0)));

    // R10
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n || !live)
        (|set_v) |=> ((status & $past(set_v)) == $past(set_v)));

    // R8
    loss_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lost |=> !lost);
endmodule

bind e1evt_status_reg e1evt_status_chk #(
    .ADDR_W(ADDR_W), .STATUS_ADDR(STATUS_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .status(st), .set_v(set_v), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .lost(tx_lost)
);

// File: tb/e1evt_status_reg_bench.sv
// Directed bench: line clocks are stepped one edge at a time; after each
// edge the register is read and cleared, so every flag is counted exactly.
module e1evt_status_reg_bench;
    import e1evt_pkg::*;

    localparam int AW   = 8;
    localparam logic [AW-1:0] SADDR = 8'h0B;
    localparam int BPF  = 8;
    localparam int FSEC = 20;
    localparam int FFST = 5;
    localparam int LOSS = 60;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [AW-1:0] host_addr = SADDR;
    logic host_wr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic timer_fast = 1'b0, rx_clk = 1'b0, rx_rst_n = 1'b0;
    logic rx_crc4_en = 1'b0, rx_crc_mark = 1'b0, rx_pat_en = 1'b0, rx_pat_hit = 1'b0;
    logic tx_clk = 1'b0, tx_rst_n = 1'b0;

    int total = 0, bad = 0;
    int tally [8];

    e1evt_status_reg #(
        .ADDR_W(AW), .STATUS_ADDR(SADDR), .BITS_PER_FRAME(BPF),
        .FRAMES_PER_ALIGN(2), .FRAMES_PER_MF(16), .FRAMES_PER_SEC(FSEC),
        .FRAMES_FAST(FFST), .LOSS_CYCLES(LOSS)
    ) u_e1evt_status_reg (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .timer_fast(timer_fast),
        .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .rx_crc4_en(rx_crc4_en),
        .rx_crc_mark(rx_crc_mark), .rx_pat_en(rx_pat_en), .rx_pat_hit(rx_pat_hit),
        .tx_clk(tx_clk), .tx_rst_n(tx_rst_n)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
        @(negedge clk);
        host_addr = a;
        host_wr   = 1'b0;
        #1 v = host_rdata;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; host_addr = SADDR;
    endtask

    task automatic zero_tally();
        for (int b = 0; b < 8; b++) tally[b] = 0;
    endtask

    task automatic take();
        logic [7:0] v;
        rd(SADDR, v);
        for (int b = 0; b < 8; b++) tally[b] += int'(v[b]);
        if (v != 8'h00) wr(SADDR, v);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rx_rst_n = 1'b0; tx_rst_n = 1'b0; host_wr = 1'b0;
        for (int i = 0; i < 4; i++) begin
            repeat (3) @(negedge clk); rx_clk = 1'b1; tx_clk = 1'b1;
            repeat (3) @(negedge clk); rx_clk = 1'b0; tx_clk = 1'b0;
        end
        @(negedge clk);
        rst_n = 1'b1; rx_rst_n = 1'b1; tx_rst_n = 1'b1;
        zero_tally();
    endtask

    task automatic rx_step(input logic mark, input logic hit);
        rx_crc_mark = mark; rx_pat_hit = hit;
        repeat (10) @(negedge clk); rx_clk = 1'b1;
        repeat (10) @(negedge clk); rx_clk = 1'b0;
        rx_crc_mark = 1'b0; rx_pat_hit = 1'b0;
        take();
    endtask

    task automatic tx_step();
        repeat (4) @(negedge clk); tx_clk = 1'b1;
        repeat (4) @(negedge clk); tx_clk = 1'b0;
        take();
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset();
        rd(SADDR, v);
        check("R1 status after reset", int'(v), 0);
    endtask

    task automatic t_rx_slow();
        do_reset();
        timer_fast = 1'b0; rx_crc4_en = 1'b0; rx_pat_en = 1'b0;
        for (int i = 1; i <= 320; i++) rx_step(i == 60, i == 50);
        check("R2 rx align count", tally[B_RX_ALIGN], 320 / (2 * BPF));
        check("R4 rx multiframe count", tally[B_RX_CAS], 320 / (16 * BPF));
        check("R5 slow timer count", tally[B_TIMER], 320 / (FSEC * BPF));
        check("R6 crc free-running, mark ignored", tally[B_RX_CRC], 320 / (16 * BPF));
        check("R7 hit ignored while disabled", tally[B_PATTERN], 0);
    endtask

    task automatic t_rx_fast();
        do_reset();
        timer_fast = 1'b1; rx_crc4_en = 1'b1; rx_pat_en = 1'b1;
        for (int i = 1; i <= 200; i++) rx_step(i == 30 || i == 90, i == 70);
        check("R5 fast timer count", tally[B_TIMER], 200 / (FFST * BPF));
        check("R6 crc marks only", tally[B_RX_CRC], 2);
        check("R7 hit while enabled", tally[B_PATTERN], 1);
        check("R2 rx align count fast run", tally[B_RX_ALIGN], 200 / (2 * BPF));
        timer_fast = 1'b0; rx_crc4_en = 1'b0; rx_pat_en = 1'b0;
    endtask

    task automatic t_tx();
        do_reset();
        for (int i = 1; i <= 300; i++) tx_step();
        check("R3 tx align count", tally[B_TX_ALIGN], 300 / (2 * BPF));
        check("R4 tx multiframe count", tally[B_TX_MF], 300 / (16 * BPF));
        check("R8 no loss while toggling", tally[B_TX_LOST], 0);
    endtask

    task automatic t_loss_and_access();
        logic [7:0] v;
        repeat (LOSS + 20) @(negedge clk);
        rd(SADDR, v);
        check("R8 loss flag after outage", int'(v[B_TX_LOST]), 1);
        wr(SADDR + 8'd1, 8'hFF);
        rd(SADDR, v);
        check("R9 other-address write ignored", int'(v[B_TX_LOST]), 1);
        rd(SADDR + 8'd1, v);
        check("R9 other-address read is zero", int'(v), 0);
        wr(SADDR, 8'h00);
        rd(SADDR, v);
        check("R9 zero write keeps bit", int'(v[B_TX_LOST]), 1);
        wr(SADDR, 8'h04);
        rd(SADDR, v);
        check("R9 one write clears bit", int'(v[B_TX_LOST]), 0);
        repeat (LOSS + 40) @(negedge clk);
        rd(SADDR, v);
        check("R8 no repeat in same outage", int'(v[B_TX_LOST]), 0);
    endtask

    task automatic t_set_wins();
        int seen;
        logic [7:0] v;
        seen = 0;
        for (int i = 0; i < 5; i++) tx_step();
        @(negedge clk);
        host_addr = SADDR; host_wdata = 8'h04; host_wr = 1'b1;
        for (int i = 0; i < LOSS + 40; i++) begin
            @(negedge clk);
            #1 if (host_rdata[B_TX_LOST]) seen++;
        end
        host_wr = 1'b0;
        check("R10 set seen under continuous clear", seen, 1);
        rd(SADDR, v);
        check("R10 bit cleared afterwards", int'(v[B_TX_LOST]), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_rx_slow();
        t_rx_fast();
        t_tx();
        t_loss_and_access();
        t_set_wins();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule